// File: doc/BRIEF.md
# Sized Add/Subtract Unit with Carry and Overflow Flags

This block sits beside a register file and carries out `destination += source` or `destination -= source` on 64-bit register values. A 2-bit size code picks the operand width: byte, half-word, word or full 64-bit. The arithmetic is done on the selected low bits only. The merged destination comes back at once on `result_o`, with the bits above the selected width copied unchanged from the old destination value.

A registered 64-bit flags word keeps the carry and signed-overflow outcome of the most recent strobed operation. Both are taken at the selected width. The carry flag sits at bit 0 and the overflow flag at bit 11. Every other flag bit keeps its previous value. A carry or overflow out of a narrow operation is recorded only in the flags and never reaches the upper destination bits. The caller presents the opcode, size, old destination and source, writes `result_o` back into its register file, and pulses `valid_i` in the same cycle to commit the flags.

Top module: `sized_addsub_flags`

## Requirements
- R1: `size_i` selects the operand width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64.
- R2: With `op_i`=0 (add), the low width bits of `result_o` equal the old destination plus the source, modulo 2^width.
- R3: With `op_i`=1 (subtract), the low width bits of `result_o` equal the old destination minus the source, modulo 2^width.
- R4: After a strobed add, flags bit 0 (carry) is 1 exactly when the unsigned sum of the low width bits does not fit in width bits.
- R5: After a strobed subtract, flags bit 0 is 1 exactly when the unsigned low source bits exceed the unsigned low destination bits, which is a borrow.
- R6: After any strobed add or subtract, flags bit 11 (overflow) is 1 exactly when the two's-complement result at the selected width is outside the signed range of that width.
- R7: The bits of `result_o` above the selected width equal the same bits of `dst_i`. No carry or borrow crosses into them.
- R8: A strobed update leaves every flag bit other than 0 and 11 unchanged.
- R9: The flags word is zero after reset and changes only on a rising clock edge where `valid_i` is 1. `result_o` is combinational and valid in the same cycle as its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flags word |
| valid_i | input | 1 | Commits this cycle's carry and overflow into the flags word |
| op_i | input | 1 | 0 = add, 1 = subtract |
| size_i | input | 2 | Operand width code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) |
| dst_i | input | 64 | Old destination value |
| src_i | input | 64 | Source value |
| result_o | output | 64 | Merged new destination value |
| flags_o | output | 64 | Registered flags word; bit 0 is carry, bit 11 is overflow |

## Verification
Carry and signed overflow can both be raised by one operation. The bench provokes this with operands such as byte 0x80 + 0x80, and with subtractions that cross the sign boundary at every width. It judges each flag bit separately against a reference model that uses range arithmetic. The bench also holds `valid_i` low while it changes operands: `result_o` must follow the new inputs at once while the flags word stays frozen. The combinational result and the registered flags are compared against the model on every clock.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;
   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } arith_op_e;

   localparam int unsigned SIZE_CODE_W = 2;
   localparam int unsigned NUM_SIZES   = 1 << SIZE_CODE_W;
   localparam int unsigned BASE_BITS   = 8;

   function automatic int unsigned width_of_code(input int unsigned code);
      return BASE_BITS << code;
   endfunction
endpackage

// File: rtl/width_mask.sv
module width_mask #(
   parameter int unsigned DATA_W = 64
) (
   input  logic [arith_flag_pkg::SIZE_CODE_W-1:0] size_i,
   output logic [DATA_W-1:0]                      mask_o,
   output logic [DATA_W-1:0]                      msb_o
);
   import arith_flag_pkg::*;

   initial begin
      if (DATA_W < BASE_BITS || (DATA_W % BASE_BITS) != 0)
         $error("width_mask: DATA_W must be a multiple of %0d", BASE_BITS);
   end

   logic [DATA_W-1:0] masks [NUM_SIZES];

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      localparam int unsigned RAW_W  = width_of_code(k);
      localparam int unsigned LANE_W = (RAW_W > DATA_W) ? DATA_W : RAW_W;
      if (LANE_W == DATA_W) begin : g_full
         assign masks[k] = '1;
      end else begin : g_part
         assign masks[k] = {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
      end
   end

   always_comb begin
      mask_o = masks[size_i];
      msb_o  = mask_o ^ (mask_o >> 1);
   end
endmodule

// File: rtl/sized_adder.sv
module sized_adder #(
   parameter int unsigned DATA_W = 64
) (
   input  logic              sub_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] mask_i,
   input  logic [DATA_W-1:0] msb_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              carry_o,
   output logic              ovf_o
);
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;
   logic              sign_a, sign_b, sign_r, cout;

   always_comb begin
      b_eff   = sub_i ? ~b_i : b_i;
      wide    = {1'b0, a_i & mask_i} + {1'b0, b_eff & mask_i}
              + {{DATA_W{1'b0}}, sub_i};
      sum_o   = wide[DATA_W-1:0];
      cout    = |(wide[DATA_W:1] & msb_i);
      sign_a  = |(a_i & msb_i);
      sign_b  = |(b_eff & msb_i);
      sign_r  = |(sum_o & msb_i);
      carry_o = cout ^ sub_i;
      ovf_o   = (sign_a == sign_b) && (sign_r != sign_a);
   end
endmodule

// File: rtl/flag_word_reg.sv
module flag_word_reg #(
   parameter int unsigned FLAG_W = 64,
   parameter int unsigned CF_BIT = 0,
   parameter int unsigned OF_BIT = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              carry_i,
   input  logic              ovf_i,
   output logic [FLAG_W-1:0] flags_o
);
   initial begin
      if (CF_BIT == OF_BIT || CF_BIT >= FLAG_W || OF_BIT >= FLAG_W)
         $error("flag_word_reg: flag positions invalid");
   end

   logic [FLAG_W-1:0] next_flags;

   for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      if (i == CF_BIT) begin : g_cf
         assign next_flags[i] = carry_i;
      end else if (i == OF_BIT) begin : g_of
         assign next_flags[i] = ovf_i;
      end else begin : g_keep
         assign next_flags[i] = flags_o[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags_o <= '0;
      else if (load_i) flags_o <= next_flags;
   end
endmodule

// File: rtl/sized_addsub_flags.sv
module sized_addsub_flags #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned FLAG_W = 64,
   parameter int unsigned CF_BIT = 0,
   parameter int unsigned OF_BIT = 11
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   valid_i,
   input  logic                                   op_i,
   input  logic [arith_flag_pkg::SIZE_CODE_W-1:0] size_i,
   input  logic [DATA_W-1:0]                      dst_i,
   input  logic [DATA_W-1:0]                      src_i,
   output logic [DATA_W-1:0]                      result_o,
   output logic [FLAG_W-1:0]                      flags_o
);
   import arith_flag_pkg::*;

   localparam logic [FLAG_W-1:0] KEEP_MASK =
      ~((FLAG_W'(1) << CF_BIT) | (FLAG_W'(1) << OF_BIT));

   initial begin
      if (DATA_W <= BASE_BITS)
         $error("sized_addsub_flags: DATA_W must exceed %0d", BASE_BITS);
   end

   logic [DATA_W-1:0] lane_mask, lane_msb, raw_sum;
   logic              carry, ovf;

   width_mask #(.DATA_W(DATA_W)) u_mask (
      .size_i (size_i),
      .mask_o (lane_mask),
      .msb_o  (lane_msb)
   );

   sized_adder #(.DATA_W(DATA_W)) u_add (
      .sub_i   (op_i == OP_SUB),
      .a_i     (dst_i),
      .b_i     (src_i),
      .mask_i  (lane_mask),
      .msb_i   (lane_msb),
      .sum_o   (raw_sum),
      .carry_o (carry),
      .ovf_o   (ovf)
   );

   assign result_o = (raw_sum & lane_mask) | (dst_i & ~lane_mask);

   flag_word_reg #(.FLAG_W(FLAG_W), .CF_BIT(CF_BIT), .OF_BIT(OF_BIT)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (valid_i),
      .carry_i (carry),
      .ovf_i   (ovf),
      .flags_o (flags_o)
   );

   always_comb begin
      if (size_i == '0)
         AST_UPPER_KEEP: assert (result_o[DATA_W-1:BASE_BITS] == dst_i[DATA_W-1:BASE_BITS]); // R7
      if (size_i == '1 && op_i == OP_ADD)
         AST_ADD_FULL: assert (result_o == dst_i + src_i); // R2
   end

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(flags_o)); // R9

   AST_FLAG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> ((flags_o & KEEP_MASK) == ($past(flags_o) & KEEP_MASK))); // R8

   AST_BORROW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == OP_SUB && size_i == '1)
      |=> (flags_o[CF_BIT] == ($past(src_i) > $past(dst_i)))); // R5
endmodule

// File: tb/tb_sized_addsub_flags.sv
`timescale 1ns/1ps
module tb_sized_addsub_flags;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic        op_i = 1'b0;
   logic [1:0]  size_i = 2'd0;
   logic [63:0] dst_i = '0;
   logic [63:0] src_i = '0;
   logic [63:0] result_o;
   logic [63:0] flags_o;

   int checks = 0;
   int errors = 0;
   logic [63:0] flags_exp = '0;

   always #2.5 clk = ~clk;

   sized_addsub_flags dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
      .size_i(size_i), .dst_i(dst_i), .src_i(src_i),
      .result_o(result_o), .flags_o(flags_o)
   );

   task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Reference model: range arithmetic at the selected width.
   task automatic model(input logic op, input logic [1:0] sz,
                        input logic [63:0] d, input logic [63:0] s,
                        output logic [63:0] res, output logic cf, output logic of);
      int w = 8 << sz;
      logic [64:0] m = (65'd1 << w) - 65'd1;
      logic [64:0] a = {1'b0, d} & m;
      logic [64:0] b = {1'b0, s} & m;
      logic signed [66:0] sa, sb, sr, smax, smin;
      logic [64:0] u;
      sa = $signed({2'b0, a}); sb = $signed({2'b0, b});
      if (a[w-1]) sa = sa - ($signed(67'd1) <<< w);
      if (b[w-1]) sb = sb - ($signed(67'd1) <<< w);
      smax = ($signed(67'd1) <<< (w-1)) - 1;
      smin = -($signed(67'd1) <<< (w-1));
      if (op == 1'b0) begin
         u  = a + b;
         cf = (u > m);
         sr = sa + sb;
      end else begin
         u  = a - b;
         cf = (b > a);
         sr = sa - sb;
      end
      of  = (sr > smax) || (sr < smin);
      res = (u[63:0] & m[63:0]) | (d & ~m[63:0]);
   endtask

   task automatic step(input string tag, input logic v, input logic op,
                       input logic [1:0] sz, input logic [63:0] d, input logic [63:0] s);
      logic [63:0] res;
      logic cf, of;
      @(negedge clk);
      check64({tag, " R9/R4/R5/R6 flags"}, flags_o, flags_exp);
      valid_i = v; op_i = op; size_i = sz; dst_i = d; src_i = s;
      #1;
      model(op, sz, d, s, res, cf, of);
      check64({tag, " R1/R2/R3/R7 result"}, result_o, res);
      if (v) begin
         flags_exp[0]  = cf;
         flags_exp[11] = of;
      end
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check64("R9 reset flags zero", flags_o, 64'd0);
      rst_n = 1'b1;
      // 32-bit cases with known outcomes
      step("R2 w32 add", 1, 0, 2, 64'hffff_0000_3b9a_ca00, 64'h0000_0000_7735_9400);
      step("R3 R5 w32 sub borrow", 1, 1, 2, 64'h1234_5678_3b9a_ca00, 64'h0000_0000_7735_9400);
      step("R6 w32 sub overflow", 1, 1, 2, 64'h0000_0000_c465_3600, 64'h0000_0000_7735_9400);
      step("R4 R6 w8 carry+ovf", 1, 0, 0, 64'haaaa_aaaa_aaaa_aa80, 64'h0000_0000_0000_0080);
      step("R7 w8 carry stays", 1, 0, 0, 64'h5555_5555_5555_55ff, 64'h0000_0000_0000_0001);
      step("R6 w8 7f+1", 1, 0, 0, 64'h0000_0000_0000_007f, 64'h1);
      step("R5 w8 0-1", 1, 1, 0, 64'hffff_ffff_ffff_ff00, 64'h1);
      step("R1 w16 add", 1, 0, 1, 64'h0123_4567_89ab_ffff, 64'hffff_ffff_ffff_0001);
      step("R6 w64 min-1", 1, 1, 3, 64'h8000_0000_0000_0000, 64'h1);
      step("R4 w64 carry", 1, 0, 3, 64'hffff_ffff_ffff_ffff, 64'h2);
      // R9: operands change while strobe is low; flags must hold
      step("R9 hold a", 0, 1, 0, 64'h0, 64'h1);
      step("R9 hold b", 0, 0, 1, 64'h7fff, 64'h1);
      step("R8 after hold", 1, 0, 1, 64'h0, 64'h0);
      for (int i = 0; i < 400; i++) begin
         step("R1 random", ($urandom_range(0, 3) != 0), $urandom_range(0, 1),
              $urandom_range(0, 3), {$urandom, $urandom}, {$urandom, $urandom});
      end
      @(negedge clk);
      check64("R8 R9 final flags", flags_o, flags_exp);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule